// File: doc/BRIEF.md
# Dual-Modulus Feedback and Reference Divider Chain

This block models the digital divider chain of an integer-N frequency synthesizer. Every register runs on one input clock, which stands in for the VCO output. A 10/11 prescaler feeds a main counter. A companion swallow counter holds the prescaler at divide-by-11 for the first part of each main cycle and lets it run at divide-by-10 for the rest. The result is the feedback pulse `fp`. A separate reference counter divides a stream of reference ticks, and each reference event arrives as a one-cycle strobe synchronous to the same clock. The result is the comparison pulse `fc`.

All settings arrive as one parallel programming word on a valid/ready input. The port never applies back-pressure: `cfg_ready` is high whenever reset is low, and a word is taken on every cycle with `cfg_valid && cfg_ready`. The divide values in a word do not act at once. Each divider takes them up when its current cycle ends, so a cycle already in progress always completes with its old ratio. The monitor controls in the word act on the cycle after the word is taken. A prescaler bypass lets the main counter run directly from the input clock.

Top module: `dm_divchain`

## Requirements
- R1: With the prescaler enabled (word bit 19 = 0), the main divider, set by M in word bits [8:0] and A in word bits [12:9], emits one `fp` pulse every 10*(M+1)+min(A,M+1) input clocks.
- R2: Within each main cycle, `mod_sel` is high for exactly the first min(A,M+1) prescaler periods, which are the divide-by-11 periods. That is 11*min(A,M+1) input clocks per main cycle.
- R3: With word bit 19 = 1, the prescaler is bypassed. `fp` repeats every M+1 input clocks, A has no effect, and `mod_sel` stays low.
- R4: The reference divider, set by R in word bits [18:13], emits one `fc` pulse for every R+1 cycles on which `ref_tick` is high. Cycles with `ref_tick` low do not advance it.
- R5: `fp` and `fc` are each one clock wide whenever their ratio is at least 2.
- R6: A newly taken word changes a divider's ratio only after that divider's current cycle ends. The interval in which the word arrives keeps the old ratio, and the next interval uses the new one.
- R7: `fp_mon` follows `fp`, except that it is held low while word bit 20 is set.
- R8: `dout` follows word bits [22:21]: 0 gives constant low, 1 gives `mod_sel`, 2 gives the raw prescaler output, 3 gives `fp`. The raw prescaler output is high on input clocks 5 and later of each prescaler period, so it is high 5*(M+1)+min(A,M+1) clocks per main cycle, and always low in bypass.
- R9: A synchronous active-high `rst` clears all counters and the stored word to zero and holds `fp` and `fc` low. After reset the main ratio is 10 and the reference ratio is 1.
- R10: `cfg_ready` is low during reset and high otherwise. A word is taken on every cycle with `cfg_valid` high outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (VCO), clocks every register |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Programming word valid |
| cfg_ready | output | 1 | Programming word ready, low only in reset |
| cfg_data | input | 23 | Programming word: M[8:0], A[12:9], R[18:13], bypass[19], fp-monitor quiet[20], dout select[22:21] |
| ref_tick | input | 1 | One-cycle strobe per reference clock event |
| fp | output | 1 | Main-divider terminal pulse |
| fp_mon | output | 1 | Gated monitor copy of `fp` |
| fc | output | 1 | Reference-divider terminal pulse |
| mod_sel | output | 1 | Prescaler modulus select (1 = divide by 11) |
| dout | output | 1 | Selected monitor signal |

## Verification
The bench builds the block with its default parameters: a low modulus of 10, a 9-bit M, a 4-bit A and a 6-bit R. It programs only small values. M runs from 0 to 11 against every A from 0 to 12, which covers both A ≤ M+1 and the saturated case A > M+1. In bypass, M runs from 0 to 31. R runs over its full 6-bit range with a tick on every cycle, and two further cases use a sparse tick. Because the values are small, each ratio and each high-count of `mod_sel`, the raw prescaler output and `fp_mon` can be checked exactly, period by period, against arithmetic. The small values also keep the mid-cycle reprogramming cases short.

// File: rtl/divchain_pkg.sv
package divchain_pkg;
  localparam int unsigned MW = 9;
  localparam int unsigned AW = 4;
  localparam int unsigned RW = 6;

  typedef enum logic [1:0] {
    MON_ZERO   = 2'd0,
    MON_MODSEL = 2'd1,
    MON_PRESC  = 2'd2,
    MON_FP     = 2'd3
  } mon_sel_e;

  typedef struct packed {
    mon_sel_e          mon;
    logic              fp_quiet;
    logic              bypass;
    logic [RW-1:0]     r;
    logic [AW-1:0]     a;
    logic [MW-1:0]     m;
  } prog_t;

  localparam int unsigned PROG_W = $bits(prog_t);
endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
  parameter int unsigned LOW_MOD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  input  logic wide,
  output logic tick,
  output logic raw
);
  localparam int unsigned CW = $clog2(LOW_MOD + 1);
  localparam logic [CW-1:0] LAST_LO = CW'(LOW_MOD - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(LOW_MOD);
  localparam logic [CW-1:0] HALF    = CW'(LOW_MOD / 2);

  logic [CW-1:0] pc;

  assign tick = bypass | (pc == (wide ? LAST_HI : LAST_LO));
  assign raw  = (pc >= HALF);

  always_ff @(posedge clk) begin
    if (rst || bypass) pc <= '0;
    else if (tick)     pc <= '0;
    else               pc <= pc + 1'b1;
  end

  // R1: phase counter never passes the divide-by-11 terminal
  p_pc_range_r1: assert property (@(posedge clk) disable iff (rst) pc <= LAST_HI);
  // R3: a bypassed prescaler holds still
  p_bypass_idle_r3: assert property (@(posedge clk) disable iff (rst) bypass |-> pc == '0);
endmodule

// File: rtl/dm_main_ctr.sv
module dm_main_ctr
  import divchain_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          pre_tick,
  input  logic          load,
  input  logic [MW-1:0] ld_m,
  input  logic [AW-1:0] ld_a,
  input  logic          ld_byp,
  output logic          term,
  output logic          fp,
  output logic          mod_hi,
  output logic          byp
);
  logic [MW-1:0] m_q, cnt;
  logic [AW-1:0] a_q;

  assign term   = pre_tick && (cnt == m_q);
  assign mod_hi = !byp && (cnt < MW'(a_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '0;
      a_q <= '0;
      byp <= 1'b0;
      cnt <= '0;
      fp  <= 1'b0;
    end else begin
      fp <= term;
      if (pre_tick) begin
        if (term) begin
          cnt <= '0;
          if (load) begin
            m_q <= ld_m;
            a_q <= ld_a;
            byp <= ld_byp;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R1: period index stays within the active M
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst) cnt <= m_q);
endmodule

// File: rtl/dm_ref_ctr.sv
module dm_ref_ctr
  import divchain_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [RW-1:0] ld_r,
  output logic          term,
  output logic          fc
);
  logic [RW-1:0] r_q, cnt;

  assign term = tick && (cnt == r_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q <= '0;
      cnt <= '0;
      fc  <= 1'b0;
    end else begin
      fc <= term;
      if (tick) begin
        if (term) begin
          cnt <= '0;
          if (load) r_q <= ld_r;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: every fc pulse follows a reference tick
  p_fc_tick_r4: assert property (@(posedge clk) disable iff (rst) fc |-> $past(tick));
endmodule

// File: rtl/dm_divchain.sv
module dm_divchain
  import divchain_pkg::*;
#(
  parameter int unsigned LOW_MOD = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [PROG_W-1:0] cfg_data,
  input  logic              ref_tick,
  output logic              fp,
  output logic              fp_mon,
  output logic              fc,
  output logic              mod_sel,
  output logic              dout
);
  prog_t stg_q, in_w;
  logic  pend_m, pend_r, accept;
  logic  m_term, r_term, pre_tick, pre_raw, byp;

  assign in_w      = prog_t'(cfg_data);
  assign cfg_ready = !rst;
  assign accept    = cfg_valid && cfg_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q  <= '0;
      pend_m <= 1'b0;
      pend_r <= 1'b0;
    end else if (accept) begin
      stg_q  <= in_w;
      pend_m <= 1'b1;
      pend_r <= 1'b1;
    end else begin
      if (m_term) pend_m <= 1'b0;
      if (r_term) pend_r <= 1'b0;
    end
  end

  dm_prescaler #(.LOW_MOD(LOW_MOD)) u_pre (
    .clk(clk), .rst(rst), .bypass(byp), .wide(mod_sel),
    .tick(pre_tick), .raw(pre_raw)
  );

  dm_main_ctr u_main (
    .clk(clk), .rst(rst), .pre_tick(pre_tick), .load(pend_m),
    .ld_m(stg_q.m), .ld_a(stg_q.a), .ld_byp(stg_q.bypass),
    .term(m_term), .fp(fp), .mod_hi(mod_sel), .byp(byp)
  );

  dm_ref_ctr u_ref (
    .clk(clk), .rst(rst), .tick(ref_tick), .load(pend_r),
    .ld_r(stg_q.r), .term(r_term), .fc(fc)
  );

  assign fp_mon = fp && !stg_q.fp_quiet;

  always_comb begin
    unique case (stg_q.mon)
      MON_MODSEL: dout = mod_sel;
      MON_PRESC:  dout = pre_raw;
      MON_FP:     dout = fp;
      default:    dout = 1'b0;
    endcase
  end

  // R9: reset silences both divider outputs
  p_rst_quiet_r9: assert property (@(posedge clk) rst |=> (!fp && !fc));
  // R7: a word with the quiet bit mutes the fp monitor from the next cycle
  p_mon_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && in_w.fp_quiet) |=> !fp_mon);
endmodule

// File: tb/sim_dm_divchain.sv
module sim_dm_divchain;
  import divchain_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst = 1'b1;
  logic              cfg_valid = 1'b0;
  logic              cfg_ready;
  logic [PROG_W-1:0] cfg_data = '0;
  logic              ref_tick = 1'b1;
  logic              fp, fp_mon, fc, mod_sel, dout;

  int n_run = 0, n_fail = 0;
  int tick_every = 1, ph = 0;
  bit done = 0;

  dm_divchain u0 (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data), .ref_tick(ref_tick), .fp(fp), .fp_mon(fp_mon),
    .fc(fc), .mod_sel(mod_sel), .dout(dout)
  );

  always @(negedge clk) begin
    if (tick_every <= 1) ref_tick <= 1'b1;
    else begin
      ref_tick <= (ph == 0);
      ph <= (ph + 1) % tick_every;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PROG_W-1:0] mk(input int m, input int a, input int r,
                                            input bit byp, input bit quiet, input int mon);
    prog_t p;
    p.m = m[MW-1:0];
    p.a = a[AW-1:0];
    p.r = r[RW-1:0];
    p.bypass = byp;
    p.fp_quiet = quiet;
    p.mon = mon_sel_e'(mon[1:0]);
    return p;
  endfunction

  task automatic prog(input logic [PROG_W-1:0] w);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_data  = w;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  // Count one interval from a pulse (fc if use_fc) to the next one.
  task automatic measure(input bit use_fc, input int inj_at, input logic [PROG_W-1:0] inj_w,
                         output int len, output int modc, output int auxc, output int monc);
    int guard = 0;
    len = 0; modc = 0; auxc = 0; monc = 0;
    while (!(use_fc ? fc : fp) && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 4000) begin
      chk(0, "pulse missing", 0, 1);
      return;
    end
    do begin
      if (len == inj_at) begin cfg_valid = 1'b1; cfg_data = inj_w; end
      if (len == inj_at + 1) cfg_valid = 1'b0;
      len++;
      modc += int'(mod_sel);
      auxc += int'(dout);
      monc += int'(fp_mon);
      @(negedge clk);
    end while (!(use_fc ? fc : fp) && len < 4000);
    cfg_valid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int len, modc, auxc, monc, k, exp;
    repeat (4) @(negedge clk);
    chk(cfg_ready == 1'b0, "R10 ready in reset", int'(cfg_ready), 0);
    chk(fp == 1'b0 && fc == 1'b0, "R9 outputs in reset", int'(fp | fc), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_ready == 1'b1, "R10 ready after reset", int'(cfg_ready), 1);
    measure(0, -5, '0, len, modc, auxc, monc);
    measure(0, -5, '0, len, modc, auxc, monc);
    chk(len == 10, "R9 default main ratio", len, 10);
    measure(1, -5, '0, len, modc, auxc, monc);
    chk(len == 1, "R9 default ref ratio", len, 1);

    // R1 R2 R5 R7 R8: prescaler enabled sweep, dout = raw prescaler
    for (int m = 0; m <= 11; m++) begin
      for (int a = 0; a <= 12; a++) begin
        bit q;
        q = ((m + a) % 2) == 1;
        k = (a < m + 1) ? a : m + 1;
        prog(mk(m, a, 0, 0, q, 2));
        measure(0, -5, '0, len, modc, auxc, monc);
        measure(0, -5, '0, len, modc, auxc, monc);
        exp = 10 * (m + 1) + k;
        chk(len == exp, $sformatf("R1 R5 ratio m=%0d a=%0d", m, a), len, exp);
        chk(modc == 11 * k, $sformatf("R2 modsel m=%0d a=%0d", m, a), modc, 11 * k);
        chk(auxc == 5 * (m + 1) + k, $sformatf("R8 raw m=%0d a=%0d", m, a), auxc, 5 * (m + 1) + k);
        chk(monc == (q ? 0 : 1), $sformatf("R7 monitor m=%0d a=%0d", m, a), monc, q ? 0 : 1);
      end
    end

    // R3: bypass sweep, dout = fp
    for (int m = 0; m <= 31; m++) begin
      prog(mk(m, 9, 0, 1, 0, 3));
      measure(0, -5, '0, len, modc, auxc, monc);
      measure(0, -5, '0, len, modc, auxc, monc);
      chk(len == m + 1, $sformatf("R3 bypass ratio m=%0d", m), len, m + 1);
      chk(modc == 0, $sformatf("R3 modsel low m=%0d", m), modc, 0);
      chk(auxc == 1, $sformatf("R8 dout fp m=%0d", m), auxc, 1);
    end

    // R8: dout = mod_sel, then raw prescaler low in bypass
    prog(mk(4, 3, 0, 0, 0, 1));
    measure(0, -5, '0, len, modc, auxc, monc);
    measure(0, -5, '0, len, modc, auxc, monc);
    chk(auxc == 33, "R8 dout modsel", auxc, 33);
    prog(mk(6, 2, 0, 1, 0, 2));
    measure(0, -5, '0, len, modc, auxc, monc);
    measure(0, -5, '0, len, modc, auxc, monc);
    chk(auxc == 0, "R8 raw low in bypass", auxc, 0);

    // R6: mid-cycle reprogramming of the main divider, dout = zero
    prog(mk(5, 2, 3, 0, 0, 0));
    measure(0, -5, '0, len, modc, auxc, monc);
    measure(0, -5, '0, len, modc, auxc, monc);
    chk(len == 62, "R6 main before", len, 62);
    measure(0, 20, mk(3, 0, 3, 0, 0, 0), len, modc, auxc, monc);
    chk(len == 62, "R6 main interval keeps old ratio", len, 62);
    chk(auxc == 0, "R8 dout zero", auxc, 0);
    measure(0, -5, '0, len, modc, auxc, monc);
    chk(len == 40, "R6 main new ratio", len, 40);

    // R4: reference sweep, tick every cycle
    for (int r = 0; r <= 63; r++) begin
      prog(mk(0, 0, r, 0, 0, 0));
      measure(1, -5, '0, len, modc, auxc, monc);
      measure(1, -5, '0, len, modc, auxc, monc);
      chk(len == r + 1, $sformatf("R4 ref ratio r=%0d", r), len, r + 1);
    end

    // R6: mid-cycle reprogramming of the reference divider
    prog(mk(0, 0, 40, 0, 0, 0));
    measure(1, -5, '0, len, modc, auxc, monc);
    measure(1, 10, mk(0, 0, 7, 0, 0, 0), len, modc, auxc, monc);
    chk(len == 41, "R6 ref interval keeps old ratio", len, 41);
    measure(1, -5, '0, len, modc, auxc, monc);
    chk(len == 8, "R6 ref new ratio", len, 8);

    // R4: sparse ticks do not advance the counter
    tick_every = 3;
    prog(mk(0, 0, 4, 0, 0, 0));
    measure(1, -5, '0, len, modc, auxc, monc);
    measure(1, -5, '0, len, modc, auxc, monc);
    chk(len == 15, "R4 sparse ticks r=4", len, 15);
    prog(mk(0, 0, 0, 0, 0, 0));
    measure(1, -5, '0, len, modc, auxc, monc);
    measure(1, -5, '0, len, modc, auxc, monc);
    chk(len == 3, "R4 sparse ticks r=0", len, 3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule